// File: doc/BRIEF.md
# Dual Command-Set Flash Sequencer

This block sits on the host side of a parallel flash bus. It drives the address, write data, a write strobe and a read strobe, and it samples the returned data. When reset is released it probes the attached device by issuing an ID-read command and reading the manufacturer code at address 0000h. That code selects one of two command sets. The first is an unlock-prefixed set that uses several bus writes per command. The second is a short set that uses one or two bus writes per command.

After the probe, the block takes high-level requests on a valid/ready port: program a word, erase a block, suspend, resume, return to read mode, or read the ID. It expands each request into the bus-write sequence that the detected set requires, and it answers every accepted request with a one-cycle response. The same request therefore produces different bus traffic depending on which device was found. If the manufacturer code is not recognised, the block latches an error and refuses all later work.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset is released, and before ready first rises, the bus carries exactly three writes, AAh@5555h, 55h@2AAAh and 90h@5555h, followed by one read at address 0000h.
- R2: A probed code equal to UNLOCK_MFR_ID (default 01h) selects the unlock set and drives cmd_set_short low. A code equal to SHORT_MFR_ID (default 89h) selects the short set and drives cmd_set_short high.
- R3: Any other probed code raises id_err, which stays high until reset. Every later request is then accepted and answered with rsp_err=1, and no bus cycle is issued.
- R4: During reset the block drives no strobe, ready is low and there is no response. Every bus access takes three cycles: a setup cycle, one strobe cycle and a hold cycle, with address and data constant across all three. The write and read strobes are never high together.
- R5: Program (req_op=0) emits AAh@5555h, 55h@2AAAh, A0h@5555h, then data@address under the unlock set. Under the short set it emits 40h@address, then data@address.
- R6: Block erase (req_op=1) emits AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h@address under the unlock set. Under the short set it emits 20h@address, then D0h@address.
- R7: Suspend (req_op=2) writes B0h under both sets. Resume (req_op=3) writes 30h under the unlock set and D0h under the short set. Reset-to-read (req_op=4) writes F0h under the unlock set and FFh under the short set. Each of these is a single write to the request address.
- R8: Read ID (req_op=5) emits AAh@5555h, 55h@2AAAh, 90h@5555h under the unlock set, or 90h@5555h under the short set. It then reads address 0000h and returns that byte on rsp_data with rsp_err=0.
- R9: req_op codes 6 and 7 cause no bus activity and are answered with rsp_err=1. The selected set is not changed.
- R10: Ready drops after an accepted request that produces bus cycles. For a request with N bus accesses, accepted at a clock edge, rsp_valid is high for exactly one cycle after the edge 3N cycles later, and ready rises again in that same cycle. A request that produces no bus access (N=0) is answered in the cycle right after acceptance. rsp_err is 0 for all valid requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 3 | Operation code (0 program, 1 erase, 2 suspend, 3 resume, 4 read mode, 5 read ID) |
| req_addr | input | AW | Target or block address |
| req_data | input | DW | Program data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request refused |
| rsp_data | output | DW | ID byte for read ID, otherwise zero |
| bus_addr | output | AW | Flash address |
| bus_dout | output | DW | Flash write data |
| bus_din | input | DW | Flash read data |
| bus_we | output | 1 | Write strobe, active high |
| bus_re | output | 1 | Read strobe, active high |
| cmd_set_short | output | 1 | 1 when the short command set is selected |
| id_err | output | 1 | Manufacturer code not recognised |

## Verification
The bench works out N, the number of bus accesses each request should produce, from the expected sequence. It accepts a request on one edge, then counts edges and expects rsp_valid to appear exactly 3N edges later, sampling on falling edges. At each intermediate sample it also checks that ready is low. The bus monitor records every write strobe on a falling edge, so each recorded address/data pair is compared with the expected list after the response. Refused requests (N=0) must respond after zero further edges and must leave the monitor empty.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_PROG   = 3'd0,
    OP_ERASE  = 3'd1,
    OP_SUSP   = 3'd2,
    OP_RESUME = 3'd3,
    OP_RDMODE = 3'd4,
    OP_READID = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } fop_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_DEAD = 2'd2
  } fst_e;

  localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
  localparam logic [15:0] ID_RD_ADDR  = 16'h0000;

  localparam logic [7:0] K_UNLK1   = 8'hAA;
  localparam logic [7:0] K_UNLK2   = 8'h55;
  localparam logic [7:0] K_PGM_U   = 8'hA0;
  localparam logic [7:0] K_ERS_U   = 8'h80;
  localparam logic [7:0] K_CONF_U  = 8'h30;
  localparam logic [7:0] K_ID      = 8'h90;
  localparam logic [7:0] K_RD_U    = 8'hF0;
  localparam logic [7:0] K_PGM_S   = 8'h40;
  localparam logic [7:0] K_ERS_S   = 8'h20;
  localparam logic [7:0] K_CONF_S  = 8'hD0;
  localparam logic [7:0] K_RD_S    = 8'hFF;
  localparam logic [7:0] K_SUSP    = 8'hB0;

endpackage

// File: rtl/fcs_cmd_table.sv
module fcs_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          set_short,
  input  fop_e          op,
  input  logic [SW-1:0] step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data,
  output logic          c_read,
  output logic          c_last
);

  localparam logic [AW-1:0] A_U1 = AW'(UNLK_ADDR_A);
  localparam logic [AW-1:0] A_U2 = AW'(UNLK_ADDR_B);
  localparam logic [AW-1:0] A_ID = AW'(ID_RD_ADDR);

  always_comb begin
    c_addr = tgt_addr;
    c_data = '0;
    c_read = 1'b0;
    c_last = 1'b1;
    if (!set_short) begin
      case (op)
        OP_PROG: begin
          c_last = (step == SW'(3));
          case (step)
            SW'(0):  begin c_addr = A_U1; c_data = DW'(K_UNLK1); end
            SW'(1):  begin c_addr = A_U2; c_data = DW'(K_UNLK2); end
            SW'(2):  begin c_addr = A_U1; c_data = DW'(K_PGM_U); end
            default: c_data = tgt_data;
          endcase
        end
        OP_ERASE: begin
          c_last = (step == SW'(5));
          case (step)
            SW'(0), SW'(3): begin c_addr = A_U1; c_data = DW'(K_UNLK1); end
            SW'(1), SW'(4): begin c_addr = A_U2; c_data = DW'(K_UNLK2); end
            SW'(2):         begin c_addr = A_U1; c_data = DW'(K_ERS_U); end
            default:        c_data = DW'(K_CONF_U);
          endcase
        end
        OP_SUSP:   c_data = DW'(K_SUSP);
        OP_RESUME: c_data = DW'(K_CONF_U);
        OP_RDMODE: c_data = DW'(K_RD_U);
        OP_READID: begin
          c_last = (step == SW'(3));
          case (step)
            SW'(0):  begin c_addr = A_U1; c_data = DW'(K_UNLK1); end
            SW'(1):  begin c_addr = A_U2; c_data = DW'(K_UNLK2); end
            SW'(2):  begin c_addr = A_U1; c_data = DW'(K_ID); end
            default: begin c_addr = A_ID; c_read = 1'b1; end
          endcase
        end
        default: c_last = 1'b1;
      endcase
    end else begin
      case (op)
        OP_PROG: begin
          c_last = (step == SW'(1));
          c_data = (step == SW'(0)) ? DW'(K_PGM_S) : tgt_data;
        end
        OP_ERASE: begin
          c_last = (step == SW'(1));
          c_data = (step == SW'(0)) ? DW'(K_ERS_S) : DW'(K_CONF_S);
        end
        OP_SUSP:   c_data = DW'(K_SUSP);
        OP_RESUME: c_data = DW'(K_CONF_S);
        OP_RDMODE: c_data = DW'(K_RD_S);
        OP_READID: begin
          c_last = (step == SW'(1));
          if (step == SW'(0)) begin
            c_addr = A_U1;
            c_data = DW'(K_ID);
          end else begin
            c_addr = A_ID;
            c_read = 1'b1;
          end
        end
        default: c_last = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/fcs_bus_phase.sv
module fcs_bus_phase #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          c_read,
  input  logic [AW-1:0] c_addr,
  input  logic [DW-1:0] c_data,
  input  logic [DW-1:0] bus_din,
  output logic          phase_end,
  output logic          bus_we,
  output logic          bus_re,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic [DW-1:0] rd_byte
);

  localparam logic [1:0] PH_SETUP  = 2'd0;
  localparam logic [1:0] PH_STROBE = 2'd1;
  localparam logic [1:0] PH_HOLD   = 2'd2;

  logic [1:0]    phase_q, phase_d;
  logic [DW-1:0] rd_q;
  logic          rd_en;

  always_comb begin
    phase_d = phase_q;
    if (!run)                   phase_d = PH_SETUP;
    else if (phase_q == PH_HOLD) phase_d = PH_SETUP;
    else                        phase_d = phase_q + 2'd1;
  end

  assign rd_en = run && (phase_q == PH_STROBE) && c_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SETUP;
      rd_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (rd_en) rd_q <= bus_din;
    end
  end

  assign phase_end = run && (phase_q == PH_HOLD);
  assign bus_we    = run && (phase_q == PH_STROBE) && !c_read;
  assign bus_re    = rd_en;
  assign bus_addr  = run ? c_addr : '0;
  assign bus_dout  = (run && !c_read) ? c_data : '0;
  assign rd_byte   = rd_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re)); // R4
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> $stable(bus_addr) && $stable(bus_dout)); // R4
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !bus_we && $stable(bus_addr) && $stable(bus_dout)); // R4
  AST_RE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> !bus_re && $stable(bus_addr)); // R4

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int          AW            = 16,
  parameter int          DW            = 8,
  parameter logic [7:0]  UNLOCK_MFR_ID = 8'h01,
  parameter logic [7:0]  SHORT_MFR_ID  = 8'h89
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  output logic          bus_we,
  output logic          bus_re,
  output logic          cmd_set_short,
  output logic          id_err
);

  localparam int SW = 3;

  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  fst_e          st_q, st_d;
  fop_e          op_q, op_d;
  logic [SW-1:0] step_q, step_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          short_q, short_d;
  logic          probe_q, probe_d;
  logic          rv_q, rv_d, re_q, re_d;
  logic [DW-1:0] rd_out_q, rd_out_d;

  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data, rd_byte;
  logic          c_read, c_last, phase_end, run;

  assign run = (st_q == ST_RUN);

  fcs_cmd_table #(.AW(AW), .DW(DW), .SW(SW)) u_table (
    .set_short (short_q),
    .op        (op_q),
    .step      (step_q),
    .tgt_addr  (addr_q),
    .tgt_data  (data_q),
    .c_addr    (c_addr),
    .c_data    (c_data),
    .c_read    (c_read),
    .c_last    (c_last)
  );

  fcs_bus_phase #(.AW(AW), .DW(DW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_s),
    .run       (run),
    .c_read    (c_read),
    .c_addr    (c_addr),
    .c_data    (c_data),
    .bus_din   (bus_din),
    .phase_end (phase_end),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .rd_byte   (rd_byte)
  );

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    step_d   = step_q;
    addr_d   = addr_q;
    data_d   = data_q;
    short_d  = short_q;
    probe_d  = probe_q;
    rv_d     = 1'b0;
    re_d     = 1'b0;
    rd_out_d = '0;
    case (st_q)
      ST_RUN: begin
        if (phase_end) begin
          if (!c_last) begin
            step_d = step_q + SW'(1);
          end else if (probe_q) begin
            probe_d = 1'b0;
            if (rd_byte == DW'(UNLOCK_MFR_ID)) begin
              short_d = 1'b0;
              st_d    = ST_IDLE;
            end else if (rd_byte == DW'(SHORT_MFR_ID)) begin
              short_d = 1'b1;
              st_d    = ST_IDLE;
            end else begin
              st_d    = ST_DEAD;
            end
          end else begin
            rv_d     = 1'b1;
            rd_out_d = (op_q == OP_READID) ? rd_byte : '0;
            st_d     = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (req_valid) begin
          if (req_op > 3'(OP_READID)) begin
            rv_d = 1'b1;
            re_d = 1'b1;
          end else begin
            st_d   = ST_RUN;
            op_d   = fop_e'(req_op);
            step_d = '0;
            addr_d = req_addr;
            data_d = req_data;
          end
        end
      end
      default: begin
        if (req_valid) begin
          rv_d = 1'b1;
          re_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q     <= ST_RUN;
      op_q     <= OP_READID;
      step_q   <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      short_q  <= 1'b0;
      probe_q  <= 1'b1;
      rv_q     <= 1'b0;
      re_q     <= 1'b0;
      rd_out_q <= '0;
    end else begin
      st_q     <= st_d;
      op_q     <= op_d;
      step_q   <= step_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
      short_q  <= short_d;
      probe_q  <= probe_d;
      rv_q     <= rv_d;
      re_q     <= re_d;
      rd_out_q <= rd_out_d;
    end
  end

  assign req_ready     = (st_q != ST_RUN);
  assign rsp_valid     = rv_q;
  assign rsp_err       = re_q;
  assign rsp_data      = rd_out_q;
  assign cmd_set_short = short_q;
  assign id_err        = (st_q == ST_DEAD);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_s)
    id_err |=> id_err); // R3
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_s)
    id_err |-> !bus_we && !bus_re); // R3
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    req_ready |-> !bus_we && !bus_re); // R10
  AST_SET_FROZEN: assert property (@(posedge clk) disable iff (!rst_s)
    (req_ready && $past(req_ready)) |-> $stable(cmd_set_short)); // R9

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, bus_din;
  logic          bus_we, bus_re, cmd_set_short, id_err;
  logic [7:0]    mfr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  assign bus_din = (bus_re && bus_addr == 16'h0000) ? mfr : 8'h00;

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_we(bus_we), .bus_re(bus_re), .cmd_set_short(cmd_set_short),
    .id_err(id_err)
  );

  logic [15:0] got_a [0:15];
  logic [7:0]  got_d [0:15];
  int          nwr = 0;
  int          nrd = 0;

  always @(negedge clk) begin
    if (bus_we) begin
      if (nwr < 16) begin
        got_a[nwr] = bus_addr;
        got_d[nwr] = bus_dout;
      end
      nwr = nwr + 1;
    end
    if (bus_re) nrd = nrd + 1;
  end

  logic [15:0] ex_a [0:7];
  logic [7:0]  ex_d [0:7];
  int          ex_w, ex_r;

  task automatic push(input logic [15:0] a, input logic [7:0] d);
    ex_a[ex_w] = a;
    ex_d[ex_w] = d;
    ex_w = ex_w + 1;
  endtask

  task automatic build(input bit sh, input int op, input logic [15:0] a, input logic [7:0] d);
    ex_w = 0;
    ex_r = 0;
    case (op)
      0: if (!sh) begin push(16'h5555,8'hAA); push(16'h2AAA,8'h55); push(16'h5555,8'hA0); push(a,d); end
         else begin push(a,8'h40); push(a,d); end
      1: if (!sh) begin
           push(16'h5555,8'hAA); push(16'h2AAA,8'h55); push(16'h5555,8'h80);
           push(16'h5555,8'hAA); push(16'h2AAA,8'h55); push(a,8'h30);
         end else begin push(a,8'h20); push(a,8'hD0); end
      2: push(a, 8'hB0);
      3: push(a, sh ? 8'hD0 : 8'h30);
      4: push(a, sh ? 8'hFF : 8'hF0);
      5: begin
           if (!sh) begin push(16'h5555,8'hAA); push(16'h2AAA,8'h55); end
           push(16'h5555,8'h90);
           ex_r = 1;
         end
      default: ;
    endcase
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_writes(input string tag);
    chk(nwr == ex_w, {tag, " write count"}, nwr, ex_w);
    chk(nrd == ex_r, {tag, " read count"}, nrd, ex_r);
    for (int i = 0; i < ex_w && i < nwr && i < 16; i++) begin
      chk(got_a[i] == ex_a[i], {tag, " write address"}, got_a[i], ex_a[i]);
      chk(got_d[i] == ex_d[i], {tag, " write data"}, got_d[i], ex_d[i]);
    end
  endtask

  task automatic do_reset(input logic [7:0] code);
    mfr = code;
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_we && !bus_re && !req_ready && !rsp_valid, "R4 reset quiet",
        {bus_we, bus_re, req_ready, rsp_valid}, 0);
    nwr = 0;
    nrd = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 200 && !req_ready; i++) @(negedge clk);
    chk(req_ready, "R1 probe completes", req_ready, 1);
    build(1'b0, 5, 16'h0000, 8'h00);
    cmp_writes("R1 probe");
  endtask

  task automatic run_req(input bit sh, input bit dead, input int op,
                         input logic [15:0] a, input logic [7:0] d);
    int n, k;
    string tg;
    if (dead) begin ex_w = 0; ex_r = 0; end
    else build(sh, op, a, d);
    if (dead) tg = "R3";
    else if (op == 0) tg = "R5";
    else if (op == 1) tg = "R6";
    else if (op < 5) tg = "R7";
    else if (op == 5) tg = "R8";
    else tg = "R9";
    n = ex_w + ex_r;
    chk(req_ready, {tg, " ready before request"}, req_ready, 1);
    nwr = 0;
    nrd = 0;
    req_op = 3'(op);
    req_addr = a;
    req_data = d;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (!rsp_valid && k < 64) begin
      if (req_ready) begin
        chk(0, "R10 ready low while busy", 1, 0);
        break;
      end
      @(posedge clk);
      @(negedge clk);
      k++;
    end
    chk(k == 3 * n, "R10 response latency", k, 3 * n);
    chk(rsp_valid && req_ready, "R10 response with ready", {rsp_valid, req_ready}, 3);
    chk(rsp_err == (dead || op > 5), {tg, " error flag"}, rsp_err, (dead || op > 5));
    if (!dead && op == 5) chk(rsp_data == mfr, "R8 id data", rsp_data, mfr);
    cmp_writes(tg);
    @(negedge clk);
    chk(!rsp_valid, "R10 single-cycle response", rsp_valid, 0);
  endtask

  initial begin
    logic [7:0] codes [0:2];
    codes[0] = 8'h01;
    codes[1] = 8'h89;
    codes[2] = 8'h5A;
    req_op = '0;
    req_addr = '0;
    req_data = '0;
    req_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      bit sh, dead;
      sh = (c == 1);
      dead = (c == 2);
      do_reset(codes[c]);
      chk(cmd_set_short == sh, "R2 set select", cmd_set_short, sh);
      chk(id_err == dead, "R3 id error flag", id_err, dead);
      for (int p = 0; p < 2; p++) begin
        for (int op = 0; op < 8; op++) begin
          run_req(sh, dead, op, 16'h1234 + 16'(op * 16'h0101) + 16'(p * 16'h4C01),
                  8'h3C ^ 8'(op) ^ 8'(p * 8'hA5));
          chk(cmd_set_short == sh, "R9 set unchanged", cmd_set_short, sh);
          chk(id_err == dead, "R3 error sticky", id_err, dead);
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule